// File: doc/BRIEF.md
# Synchronous Bus Read Responder

This block answers single read transfers on a synchronous parallel bus. On each rising clock edge it samples a one-cycle transfer-start strobe together with the read/write line and the address. When the strobe is high, the line says read and the address lies inside the block's own address window, the block fetches one 32-bit word from its internal store. It then places the requested bytes on the correct lanes of the data bus, raises transfer acknowledge for one clock and releases the bus again.

Lane placement has two sources, chosen by a mode input. In one mode the size code and the two low address bits decide the lanes. In the other mode four byte-select lines name the lanes directly. A programmable wait count from 0 to 7 stretches the time between the start strobe and the acknowledge. The bus driver is exposed as a data word plus an output-enable, and the chip's pad ring turns that pair into the tri-state pins. Write cycles, bursts and retry or error endings are left to other blocks.

The store is a read-only word array. Its contents are computed at elaboration, so it maps onto block RAM with a registered read port.

Top module: `bus_read_responder`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `xfer_ack` and `data_oe` are 0 and `data_out` is 0. A reset during a transfer cancels it, so no acknowledge follows.
- R2: A transfer is accepted only when `xfer_start`=1, `rd_wrn`=1 and `BASE_ADDR <= addr < BASE_ADDR + 4*DEPTH`. A start with an address outside that window produces no acknowledge and no output enable.
- R3: A start with `rd_wrn`=0 (write) is ignored, so no acknowledge and no output enable follow.
- R4: If the start is sampled at edge E0 with wait count W, then `xfer_ack` is 1 exactly from edge E(W+1) to edge E(W+2), one clock only.
- R5: `data_oe` is 1 in exactly the same cycle as `xfer_ack`, and `data_out` is 0 whenever `data_oe` is 0.
- R6: Word i of the store (at byte address `BASE_ADDR + 4*i`) holds, at byte offset b, the value `(4*i + b) XOR 0x5A`.
- R7: With `sel_mode`=0, lanes follow the size code and `addr[1:0]`. Size 01 is a byte on offset `addr[1:0]`. Size 10 is a word on offsets `{addr[1],0}` and `{addr[1],1}`. Sizes 00 and 11 are a long word on all four offsets. Lanes are big-endian: offset 0 is `data_out[31:24]` and offset 3 is `data_out[7:0]`.
- R8: With `sel_mode`=1, `byte_sel[k]` enables `data_out[8k+7:8k]`. The size code and `addr[1:0]` then have no effect on the lanes, and an all-zero `byte_sel` gives an acknowledge with zero data.
- R9: While `data_oe` is 1, every lane that is not selected is driven to 0.
- R10: A start strobe seen while a transfer is in progress is ignored. That transfer's data and timing do not change, and no second acknowledge follows.
- R11: The wait count is sampled with the start strobe. Later changes of `wait_states` do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Transfer-start strobe, one clock wide |
| rd_wrn | input | 1 | 1 = read, 0 = write |
| addr | input | AW (32) | Byte address of the transfer |
| size | input | 2 | Size code: 01 byte, 10 word, 00/11 long word |
| byte_sel | input | DW/8 (4) | Per-lane select, bit k for data bits 8k+7..8k |
| sel_mode | input | 1 | 0 = lanes from size and address, 1 = lanes from byte_sel |
| wait_states | input | WAITW (3) | Wait count added before the acknowledge |
| data_out | output | DW (32) | Data for the bus pads |
| data_oe | output | 1 | Pad output enable; 0 means high impedance |
| xfer_ack | output | 1 | Transfer acknowledge, one clock wide |

## Verification
The bench builds the block with its defaults: a 16-word store based at 0x8000_0040 and a 3-bit wait count. This places the window's first and last words, and the addresses just below and just above it, on short literal addresses. A 16-word store keeps every byte value distinct, so a word fetched from the wrong index shows up in the data check. The 3-bit wait field puts both the zero-wait and the seven-wait extremes within reach, along with a wait change in the middle of a transfer.

// File: rtl/bus_rd_pkg.sv
package bus_rd_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRIVE = 2'd2
  } resp_state_e;

endpackage

// File: rtl/addr_window_decode.sv
module addr_window_decode #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter logic [AW-1:0] BASE_ADDR = 'h8000_0040
) (
  input  logic [AW-1:0]                 addr,
  output logic                          hit,
  output logic [$clog2(DEPTH)-1:0]      idx,
  output logic [$clog2(DW/8)-1:0]       offs
);
  localparam int NL   = DW / 8;
  localparam int OFFW = $clog2(NL);
  localparam int IDXW = $clog2(DEPTH);
  localparam int TAGL = IDXW + OFFW;
  localparam logic [AW:0] WIN_LO = {1'b0, BASE_ADDR};
  localparam logic [AW:0] WIN_HI = WIN_LO + (AW+1)'(NL * DEPTH);

  always_comb begin
    hit  = (addr[AW-1:TAGL] == BASE_ADDR[AW-1:TAGL]);
    idx  = addr[TAGL-1:OFFW];
    offs = addr[OFFW-1:0];
  end

  // R2: a hit must lie inside the arithmetic window bounds
  always_comb begin
    if (hit) begin
      assert_hit_in_window_R2: assert (({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI));
    end
  end

endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter logic [7:0] SEED = 8'h5A
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);
  localparam int NL = DW / 8;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      for (int b = 0; b < NL; b++) begin
        mem[i][DW-1-8*b -: 8] = 8'(i * NL + b) ^ SEED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import bus_rd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]            word,
  input  xfer_size_e               size,
  input  logic [$clog2(DW/8)-1:0]  offs,
  input  logic [DW/8-1:0]          bsel,
  input  logic                     sel_mode,
  output logic [DW/8-1:0]          mask,
  output logic [DW-1:0]            steered
);
  localparam int NL   = DW / 8;
  localparam int OFFW = $clog2(NL);

  for (genvar k = 0; k < NL; k++) begin : g_lane
    localparam logic [OFFW-1:0] LANE_OFF = OFFW'(NL - 1 - k);
    logic sz_sel;

    always_comb begin
      unique case (size)
        SZ_BYTE: sz_sel = (offs == LANE_OFF);
        SZ_WORD: sz_sel = (offs[OFFW-1:1] == LANE_OFF[OFFW-1:1]);
        default: sz_sel = 1'b1;
      endcase
      mask[k]          = sel_mode ? bsel[k] : sz_sel;
      steered[8*k +: 8] = mask[k] ? word[8*k +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/bus_read_responder.sv
module bus_read_responder
  import bus_rd_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int WAITW = 3,
  parameter logic [AW-1:0] BASE_ADDR = 'h8000_0040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_start,
  input  logic              rd_wrn,
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        size,
  input  logic [DW/8-1:0]   byte_sel,
  input  logic              sel_mode,
  input  logic [WAITW-1:0]  wait_states,
  output logic [DW-1:0]     data_out,
  output logic              data_oe,
  output logic              xfer_ack
);
  localparam int NL   = DW / 8;
  localparam int OFFW = $clog2(NL);
  localparam int IDXW = $clog2(DEPTH);

  resp_state_e      state;
  logic [WAITW-1:0] cnt;
  logic             hit;
  logic [IDXW-1:0]  idx;
  logic [OFFW-1:0]  offs;
  logic             accept;

  xfer_size_e       size_q;
  logic [OFFW-1:0]  offs_q;
  logic [NL-1:0]    bsel_q;
  logic             mode_q;
  logic [IDXW-1:0]  idx_q;
  logic [NL-1:0]    mask_q;

  logic [DW-1:0]    rd_word;
  logic [NL-1:0]    lane_mask;
  logic [DW-1:0]    lane_data;

  addr_window_decode #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(addr), .hit(hit), .idx(idx), .offs(offs)
  );

  assign accept = (state == ST_IDLE) && xfer_start && rd_wrn && hit;

  word_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rd_en(accept), .rd_idx(idx), .rd_data(rd_word)
  );

  lane_steer #(.DW(DW)) u_steer (
    .word(rd_word), .size(size_q), .offs(offs_q), .bsel(bsel_q),
    .sel_mode(mode_q), .mask(lane_mask), .steered(lane_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      size_q   <= SZ_LONG;
      offs_q   <= '0;
      bsel_q   <= '0;
      mode_q   <= 1'b0;
      idx_q    <= '0;
      mask_q   <= '0;
      data_out <= '0;
      data_oe  <= 1'b0;
      xfer_ack <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            size_q <= xfer_size_e'(size);
            offs_q <= offs;
            bsel_q <= byte_sel;
            mode_q <= sel_mode;
            idx_q  <= idx;
            cnt    <= wait_states;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (cnt == '0) begin
            data_out <= lane_data;
            mask_q   <= lane_mask;
            data_oe  <= 1'b1;
            xfer_ack <= 1'b1;
            state    <= ST_DRIVE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          data_out <= '0;
          data_oe  <= 1'b0;
          xfer_ack <= 1'b0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  // R4: acknowledge lasts a single clock
  assert_ack_single_R4: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |=> !xfer_ack);

  // R5: bus released means zero data
  assert_zero_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));

  // R3: a write strobe in idle leaves the responder idle
  assert_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && xfer_start && !rd_wrn) |=> (state == ST_IDLE));

  // R10: a strobe during a transfer does not touch the captured request
  assert_busy_strobe_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && xfer_start) |=> ($stable(idx_q) && $stable(bsel_q)));

  // R11: the wait counter only counts down once captured
  assert_wait_countdown_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R9: unselected lanes carry zero while driving
  for (genvar k = 0; k < NL; k++) begin : g_lane_chk
    assert_unsel_lane_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (data_oe && !mask_q[k]) |-> (data_out[8*k +: 8] == 8'h00));
  end

endmodule

// File: tb/bus_read_responder_tb.sv
module bus_read_responder_tb;

  localparam logic [31:0] BASE = 32'h8000_0040;

  logic        clk = 1'b0;
  logic        rst;
  logic        xfer_start;
  logic        rd_wrn;
  logic [31:0] addr;
  logic [1:0]  size;
  logic [3:0]  byte_sel;
  logic        sel_mode;
  logic [2:0]  wait_states;
  logic [31:0] data_out;
  logic        data_oe;
  logic        xfer_ack;

  int checks = 0;
  int fails  = 0;

  bus_read_responder u_dut (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .rd_wrn(rd_wrn),
    .addr(addr), .size(size), .byte_sel(byte_sel), .sel_mode(sel_mode),
    .wait_states(wait_states), .data_out(data_out), .data_oe(data_oe),
    .xfer_ack(xfer_ack)
  );

  always #5 clk = ~clk;

  // {addr, size, byte_sel, sel_mode, wait, expected data}
  localparam int NV = 10;
  localparam logic [73:0] VEC [NV] = '{
    {32'h8000_0040, 2'b00, 4'b0000, 1'b0, 3'd0, 32'h5A5B_5859}, // R7 long, first word
    {32'h8000_0045, 2'b01, 4'b0000, 1'b0, 3'd1, 32'h005F_0000}, // R7 byte offset 1
    {32'h8000_004E, 2'b10, 4'b0000, 1'b0, 3'd2, 32'h0000_5455}, // R7 word, upper half
    {32'h8000_004C, 2'b10, 4'b0000, 1'b0, 3'd0, 32'h5657_0000}, // R7 word, lower half
    {32'h8000_007F, 2'b01, 4'b0000, 1'b0, 3'd7, 32'h0000_0065}, // R7 R6 last byte, max wait
    {32'h8000_0054, 2'b11, 4'b0000, 1'b0, 3'd3, 32'h4E4F_4C4D}, // R7 size 11 as long
    {32'h8000_0060, 2'b01, 4'b1010, 1'b1, 3'd0, 32'h7A00_7800}, // R8 R9 byte-select
    {32'h8000_007C, 2'b00, 4'b0001, 1'b1, 3'd5, 32'h0000_0065}, // R8 size ignored
    {32'h8000_0040, 2'b00, 4'b0000, 1'b1, 3'd1, 32'h0000_0000}, // R8 no lanes
    {32'h8000_0040, 2'b01, 4'b0000, 1'b0, 3'd4, 32'h5A00_0000}  // R7 byte offset 0
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    xfer_start = 1'b0; rd_wrn = 1'b1; addr = '0; size = 2'b00;
    byte_sel = '0; sel_mode = 1'b0; wait_states = '0;
  endtask

  // Drives one read and checks timing (R4, R5) and data at the ack cycle.
  task automatic do_read(input logic [31:0] a, input logic [1:0] sz,
                         input logic [3:0] bs, input logic md, input logic [2:0] w,
                         input logic [31:0] exp, input logic [2:0] w_after,
                         input bit retrig, input string tag);
    bit ok_t = 1'b1;
    logic [31:0] got = '0;
    @(negedge clk);
    xfer_start = 1'b1; rd_wrn = 1'b1; addr = a; size = sz;
    byte_sel = bs; sel_mode = md; wait_states = w;
    @(posedge clk);
    @(negedge clk);
    xfer_start = 1'b0; wait_states = w_after;
    for (int k = 1; k <= int'(w) + 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (xfer_ack !== (k == int'(w) + 1)) ok_t = 1'b0;
      if (data_oe !== xfer_ack) ok_t = 1'b0;
      if (!data_oe && data_out !== 32'h0) ok_t = 1'b0;
      if (k == int'(w) + 1) got = data_out;
      if (retrig && k == 1) begin
        xfer_start = 1'b1; addr = BASE + 32'h3C; size = 2'b00; sel_mode = 1'b0;
      end
      if (retrig && k == 2) xfer_start = 1'b0;
    end
    check(ok_t, {tag, " R4 R5 ack/oe timing"}, {31'h0, xfer_ack}, {31'h0, 1'b0});
    check(got === exp, {tag, " data"}, got, exp);
    idle_inputs();
  endtask

  task automatic quiet(input int n, input string req);
    bit ok = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (xfer_ack !== 1'b0 || data_oe !== 1'b0) ok = 1'b0;
    end
    check(ok, req, {30'h0, xfer_ack, data_oe}, 32'h0);
  endtask

  task automatic start_pulse(input logic [31:0] a, input logic rw);
    @(negedge clk);
    xfer_start = 1'b1; rd_wrn = rw; addr = a; size = 2'b00; wait_states = 3'd0;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(xfer_ack === 1'b0 && data_oe === 1'b0 && data_out === 32'h0,
          "R1 outputs in reset", data_out, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(xfer_ack === 1'b0 && data_oe === 1'b0 && data_out === 32'h0,
          "R1 outputs after reset", data_out, 32'h0);

    // vector table: R6 R7 R8 R9 content and lane placement
    for (int v = 0; v < NV; v++) begin
      do_read(VEC[v][73:42], VEC[v][41:40], VEC[v][39:36], VEC[v][35],
              VEC[v][34:32], VEC[v][31:0], VEC[v][34:32], 1'b0, "R6 R7 R8 R9 vector");
    end

    // R2: just below and just above the window
    start_pulse(BASE - 32'd4, 1'b1);
    quiet(10, "R2 below window");
    start_pulse(BASE + 32'd64, 1'b1);
    quiet(10, "R2 above window");

    // R3: write strobe inside the window
    start_pulse(BASE + 32'd8, 1'b0);
    quiet(10, "R3 write ignored");

    // R10: second strobe while busy; data of first transfer (word 1)
    do_read(BASE + 32'd4, 2'b00, 4'b0000, 1'b0, 3'd5, 32'h5E5F_5C5D, 3'd5, 1'b1,
            "R10 busy strobe");
    quiet(6, "R10 no second ack");

    // R11: wait count raised to 7 after the strobe; ack still at W=2
    do_read(BASE + 32'd32, 2'b00, 4'b0000, 1'b0, 3'd2, 32'h7A7B_7879, 3'd7, 1'b0,
            "R11 wait sampled once");

    // R1: reset during a transfer cancels it
    @(negedge clk);
    xfer_start = 1'b1; rd_wrn = 1'b1; addr = BASE; wait_states = 3'd3;
    @(negedge clk);
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    quiet(8, "R1 reset cancels transfer");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule